// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Three-Bit Instruction Register

This block is the serial test port of a memory device. A four-wire scan interface (test clock, mode select, serial data in, serial data out) steers a sixteen-state controller. Through it, a tester selects one of several shift paths between serial input and serial output: a one-bit pass-through register, a 32-bit identification register, or a boundary register. The boundary register has one cell per device pin, and its length is a parameter.

The boundary register loads a parallel snapshot of the pin values (`pin_cap`). It holds a separate update stage whose contents appear on `pin_drv`. A test-drive flag tells the surrounding pad logic to use `pin_drv` in place of the functional values. A second flag asks the pad logic to place every functional output in high impedance. The port has no dedicated test-reset pin. The controller returns to its reset state when mode select is held high for five test-clock rising edges. An active-low synchronous power-up reset `rst_n` puts it in the same state.

Top module: `jtag_tap_port`

## Requirements
- R1: While `rst_n` is low at a rising TCK edge, the controller enters Test-Logic-Reset and the active instruction becomes IDCODE (001). After that edge `extest_on`, `hiz_req` and `pin_drv` read 0, and `tdo_oe` reads 0 from the next falling edge on.
- R2: The controller follows the sixteen-state IEEE 1149.1 transition graph, with `tms` sampled on the rising edge of `tck`. On each falling edge, `tdo_oe` becomes 1 exactly when the controller is in Shift-IR or Shift-DR, and `tdo` is updated only on falling edges.
- R3: From any state, five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset. The rising edge taken in that state restores IDCODE as the active instruction.
- R4: In Capture-IR, the instruction shift register loads binary 001. Shifted out least significant bit first, this is seen on `tdo` as 1, 0, 0.
- R5: Instruction bits shift in least significant bit first. The active instruction, and with it `extest_on` and `hiz_req`, changes only on the rising edge taken in Update-IR and stays unchanged through Shift-IR, Exit1-IR and Update-IR itself.
- R6: Under IDCODE (001), Capture-DR loads the 32-bit identification value with bit 0 forced to 1. Shift-DR presents it on `tdo` least significant bit first.
- R7: Opcodes 011, 101, 110 and 111 select the one-bit pass-through register. It loads 0 in Capture-DR, so `tdo` shows 0 and then the `tdi` stream delayed by one shift.
- R8: Under SAMPLE/PRELOAD (100), Capture-DR loads `pin_cap` into the boundary register and Shift-DR presents it on `tdo` from bit 0 upward. The shifted-in vector appears on `pin_drv` after Update-DR, while `extest_on` stays 0.
- R9: Under EXTEST (000), `extest_on` is 1 and the boundary register captures `pin_cap`. The vector shifted in appears on `pin_drv` after Update-DR.
- R10: Under SAMPLE-Z (010), `hiz_req` is 1, `extest_on` is 0 and the boundary register captures and shifts `pin_cap`. Update-DR leaves `pin_drv` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Power-up reset, active low, synchronous to `tck` |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pin_cap | input | BSR_LEN | Pin values snapshotted into the boundary register |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | High while a shift state drives `tdo` |
| pin_drv | output | BSR_LEN | Boundary update stage, values for the pins under test drive |
| extest_on | output | 1 | Test-drive instruction active: pads take `pin_drv` |
| hiz_req | output | 1 | High-impedance instruction active: functional outputs off |

## Verification
The assertions assume three things about the inputs. `tms` and `tdi` are stable around each rising `tck` edge. `rst_n` is held low across at least two rising edges, so that one falling edge falls inside the reset. `pin_cap` does not change in the cycle the boundary register captures it. The bench meets these by changing `tms` and `tdi` only just after a falling edge and by holding reset for three cycles. It sets `pin_cap` well before the capture state is reached, and it samples `tdo` and `tdo_oe` one nanosecond after each falling edge. A bench-side model of the transition graph walks all 32 transitions. That model sets the expected `tdo_oe`, and a queue of expected serial bits holds the expected `tdo` values.

// File: rtl/jtag_tap_pkg.sv
// Shared definitions for the scan port: controller states, opcodes,
// data-register selection and the transition function.
// Assumes a three-bit instruction register with a fixed opcode map.
package jtag_tap_pkg;

    localparam int IR_W = 3;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;

    // Pattern loaded in Capture-IR (two LSBs fixed at 01).
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        S_RESET, S_IDLE,
        S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_BOUND} dr_sel_e;

    // Next controller state for a given mode-select value.
    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        case (s)
            S_RESET:  return tms ? S_RESET  : S_IDLE;
            S_IDLE:   return tms ? S_SEL_DR : S_IDLE;
            S_SEL_DR: return tms ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: return tms ? S_EX1_DR : S_SH_DR;
            S_SH_DR:  return tms ? S_EX1_DR : S_SH_DR;
            S_EX1_DR: return tms ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: return tms ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: return tms ? S_UPD_DR : S_SH_DR;
            S_UPD_DR: return tms ? S_SEL_DR : S_IDLE;
            S_SEL_IR: return tms ? S_RESET  : S_CAP_IR;
            S_CAP_IR: return tms ? S_EX1_IR : S_SH_IR;
            S_SH_IR:  return tms ? S_EX1_IR : S_SH_IR;
            S_EX1_IR: return tms ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: return tms ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: return tms ? S_UPD_IR : S_SH_IR;
            S_UPD_IR: return tms ? S_SEL_DR : S_IDLE;
            default:  return S_RESET;
        endcase
    endfunction

    // Which data register an opcode places between serial in and out.
    function automatic dr_sel_e dr_select(input logic [IR_W-1:0] op);
        case (op)
            OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: return DR_BOUND;
            OP_IDCODE:                        return DR_IDENT;
            default:                          return DR_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state scan controller. Advances on every rising test clock.
// Assumes tms is settled before the rising edge; rst_n is synchronous.
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e st
);

    // State register: reset state on power-up, graph step otherwise.
    always_ff @(posedge tck) begin
        if (!rst_n) st <= S_RESET;
        else        st <= tap_next(st, tms);
    end

endmodule

// File: rtl/tap_ir.sv
// Instruction shift stage and active instruction.
// Assumes the controller state from tap_fsm. The active instruction
// changes only in Update-IR and returns to IDCODE in Test-Logic-Reset.
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  tap_state_e      st,
    output logic [IR_W-1:0] ir_sr,
    output logic [IR_W-1:0] ir_q
);

    // Shift stage: capture fixed pattern, then shift LSB-first.
    always_ff @(posedge tck) begin
        if (!rst_n)              ir_sr <= '0;
        else if (st == S_CAP_IR) ir_sr <= IR_CAPTURE;
        else if (st == S_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Active instruction: default IDCODE, loaded from shift stage on update.
    always_ff @(posedge tck) begin
        if (!rst_n || st == S_RESET) ir_q <= OP_IDCODE;
        else if (st == S_UPD_IR)     ir_q <= ir_sr;
    end

endmodule

// File: rtl/tap_dr.sv
// Data registers: one-bit pass-through, identification, boundary cells
// with update stage. Assumes pin_cap is stable during Capture-DR.
module tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_LEN  = 16,
    parameter logic [31:0] ID_VALUE = 32'h1A2B_3C4D
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tdi,
    input  tap_state_e         st,
    input  logic [IR_W-1:0]    ir_q,
    input  logic [BSR_LEN-1:0] pin_cap,
    output logic               byp_q,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] pin_drv
);

    localparam int ID_W = 32;
    localparam logic [ID_W-1:0] ID_CAP = {ID_VALUE[ID_W-1:1], 1'b1};

    dr_sel_e            sel;
    logic               cap_en, sh_en, upd_en, drv_load;
    logic [ID_W-1:0]    id_sr;
    logic [BSR_LEN-1:0] bsr_sr, bsr_nxt, bsr_shin;

    assign sel      = dr_select(ir_q);
    assign cap_en   = (st == S_CAP_DR);
    assign sh_en    = (st == S_SH_DR);
    assign upd_en   = (st == S_UPD_DR);
    assign drv_load = upd_en && (ir_q == OP_EXTEST || ir_q == OP_SAMPLE);
    assign bsr_shin = {tdi, bsr_sr[BSR_LEN-1:1]};

    // One boundary cell per pin: hold, capture pin or take neighbour.
    for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
        assign bsr_nxt[i] = (sel != DR_BOUND) ? bsr_sr[i]  :
                            cap_en            ? pin_cap[i] :
                            sh_en             ? bsr_shin[i] : bsr_sr[i];
    end

    // Pass-through bit: capture 0, shift tdi.
    always_ff @(posedge tck) begin
        if (!rst_n)                                byp_q <= 1'b0;
        else if (sel == DR_BYPASS && cap_en)       byp_q <= 1'b0;
        else if (sel == DR_BYPASS && sh_en)        byp_q <= tdi;
    end

    // Identification register: capture constant, shift LSB-first.
    always_ff @(posedge tck) begin
        if (!rst_n)                                id_sr <= '0;
        else if (sel == DR_IDENT && cap_en)        id_sr <= ID_CAP;
        else if (sel == DR_IDENT && sh_en)         id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // Boundary shift stage.
    always_ff @(posedge tck) begin
        if (!rst_n) bsr_sr <= '0;
        else        bsr_sr <= bsr_nxt;
    end

    // Boundary update stage: loaded on Update-DR for preload and drive.
    always_ff @(posedge tck) begin
        if (!rst_n)        pin_drv <= '0;
        else if (drv_load) pin_drv <= bsr_sr;
    end

    // Serial output bit of the selected register.
    always_comb begin
        case (sel)
            DR_IDENT: dr_lsb = id_sr[0];
            DR_BOUND: dr_lsb = bsr_sr[0];
            default:  dr_lsb = byp_q;
        endcase
    end

endmodule

// File: rtl/jtag_tap_port.sv
// Top of the scan port: controller, instruction and data registers,
// and falling-edge retiming of the serial output.
// Assumes rst_n spans at least one falling edge while low.
module jtag_tap_port
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_LEN  = 16,
    parameter logic [31:0] ID_VALUE = 32'h1A2B_3C4D
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_cap,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [BSR_LEN-1:0] pin_drv,
    output logic               extest_on,
    output logic               hiz_req
);

    tap_state_e      st;
    logic [IR_W-1:0] ir_sr, ir_q;
    logic            byp_q, dr_lsb;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .st    (st)
    );

    tap_ir u_ir (
        .tck   (tck),
        .rst_n (rst_n),
        .tdi   (tdi),
        .st    (st),
        .ir_sr (ir_sr),
        .ir_q  (ir_q)
    );

    tap_dr #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck     (tck),
        .rst_n   (rst_n),
        .tdi     (tdi),
        .st      (st),
        .ir_q    (ir_q),
        .pin_cap (pin_cap),
        .byp_q   (byp_q),
        .dr_lsb  (dr_lsb),
        .pin_drv (pin_drv)
    );

    assign extest_on = (ir_q == OP_EXTEST);
    assign hiz_req   = (ir_q == OP_SAMPLEZ);

    // Serial output retimed to the falling edge, enabled in shift states.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else if (st == S_SH_IR) begin
            tdo    <= ir_sr[0];
            tdo_oe <= 1'b1;
        end else if (st == S_SH_DR) begin
            tdo    <= dr_lsb;
            tdo_oe <= 1'b1;
        end else begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end
    end

endmodule

// File: rtl/tap_port_chk.sv
// Property checker for jtag_tap_port, attached by bind below.
// Assumes the controller state and instruction nets of the top.
module tap_port_chk
    import jtag_tap_pkg::*;
#(
    parameter int BSR_LEN = 16
) (
    input logic               tck,
    input logic               rst_n,
    input tap_state_e         st,
    input logic [IR_W-1:0]    ir_sr,
    input logic [IR_W-1:0]    ir_q,
    input logic               byp_q,
    input logic               tdo_oe,
    input logic               extest_on,
    input logic               hiz_req,
    input logic [BSR_LEN-1:0] pin_drv
);

    logic byp_sel;
    assign byp_sel = (ir_q == 3'b011) || (ir_q == 3'b101) ||
                     (ir_q == 3'b110) || (ir_q == 3'b111);

    // R1: a reset edge leaves the pad controls quiet
    a_r1_reset_quiet: assert property (@(posedge tck)
        !rst_n |=> (!extest_on && !hiz_req && pin_drv == '0));

    // R2: output enable set on the falling edge only for shift states
    a_r2_oe_shift: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe == (st == S_SH_DR || st == S_SH_IR));

    // R3: Test-Logic-Reset restores the default instruction
    a_r3_reset_idcode: assert property (@(posedge tck) disable iff (!rst_n)
        st == S_RESET |=> ir_q == OP_IDCODE);

    // R4: Capture-IR loads the fixed pattern
    a_r4_ir_capture: assert property (@(posedge tck) disable iff (!rst_n)
        st == S_CAP_IR |=> ir_sr == 3'b001);

    // R5: instruction-driven flags change only after Update-IR or reset state
    a_r5_update_only: assert property (@(posedge tck) disable iff (!rst_n)
        !($stable(extest_on) && $stable(hiz_req)) |->
            ($past(st) == S_UPD_IR || $past(st) == S_RESET));

    // R7: pass-through bit captures zero
    a_r7_bypass_zero: assert property (@(posedge tck) disable iff (!rst_n)
        (st == S_CAP_DR && byp_sel) |=> !byp_q);

    // R10: Update-DR under the high-impedance instruction keeps the drive vector
    a_r10_hiz_hold: assert property (@(posedge tck) disable iff (!rst_n)
        (st == S_UPD_DR && hiz_req) |=> $stable(pin_drv));

endmodule

bind jtag_tap_port tap_port_chk #(.BSR_LEN(BSR_LEN)) u_chk (
    .tck       (tck),
    .rst_n     (rst_n),
    .st        (st),
    .ir_sr     (ir_sr),
    .ir_q      (ir_q),
    .byp_q     (byp_q),
    .tdo_oe    (tdo_oe),
    .extest_on (extest_on),
    .hiz_req   (hiz_req),
    .pin_drv   (pin_drv)
);

// File: tb/jtag_tap_port_tb.sv
`timescale 1ns/1ps
module jtag_tap_port_tb;

    localparam int          BL     = 16;
    localparam logic [31:0] ID_VAL = 32'h1A2B_3C4D;

    // Bench-side state codes for the reference transition graph.
    localparam int TLR = 0,  RTI = 1,  SDS = 2,  CDR = 3,  SHD = 4,  E1D = 5,
                   PD  = 6,  E2D = 7,  UDR = 8,  SIS = 9,  CIR = 10, SHI = 11,
                   E1I = 12, PI  = 13, E2I = 14, UIR = 15;

    logic          tck = 1'b0;
    logic          rst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b1;
    logic [BL-1:0] pin_cap = '0;
    logic          tdo, tdo_oe, extest_on, hiz_req;
    logic [BL-1:0] pin_drv;

    int   n_chk = 0;
    int   n_err = 0;
    int   mst = TLR;
    bit   sb_on = 1'b0;
    bit   finished = 1'b0;
    logic [2:0] cur_op = 3'b001;

    typedef struct {logic v; string req;} exp_t;
    exp_t sb_q[$];

    jtag_tap_port #(.BSR_LEN(BL), .ID_VALUE(ID_VAL)) u_dut (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .pin_cap(pin_cap),
        .tdo(tdo), .tdo_oe(tdo_oe), .pin_drv(pin_drv),
        .extest_on(extest_on), .hiz_req(hiz_req)
    );

    always #2.5 tck = ~tck;

    function automatic int b_next(input int s, input logic m);
        case (s)
            TLR: return m ? TLR : RTI;   RTI: return m ? SDS : RTI;
            SDS: return m ? SIS : CDR;   CDR: return m ? E1D : SHD;
            SHD: return m ? E1D : SHD;   E1D: return m ? UDR : PD;
            PD:  return m ? E2D : PD;    E2D: return m ? UDR : SHD;
            UDR: return m ? SDS : RTI;   SIS: return m ? TLR : CIR;
            CIR: return m ? E1I : SHI;   SHI: return m ? E1I : SHI;
            E1I: return m ? UIR : PI;    PI:  return m ? E2I : PI;
            E2I: return m ? UIR : SHI;   UIR: return m ? SDS : RTI;
            default: return TLR;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic v, input string req);
        exp_t e;
        e.v = v; e.req = req;
        sb_q.push_back(e);
    endtask

    // Driver primitive: drive after falling edge, advance model at rising edge.
    task automatic step(input logic m, input logic d);
        @(negedge tck); #0.5;
        tms = m; tdi = d;
        @(posedge tck);
        mst = b_next(mst, m);
        #1;
    endtask

    // From Run-Test/Idle: load an opcode and return to Run-Test/Idle.
    task automatic load_ir(input logic [2:0] op);
        push(1'b1, "R4 capture bit0"); push(1'b0, "R4 capture bit1"); push(1'b0, "R4 capture bit2");
        step(1, 1); step(1, 1); step(0, 1); step(0, 1);
        step(0, op[0]); step(0, op[1]); step(1, op[2]);
        check(extest_on == (cur_op == 3'b000), "R5 extest before update (Exit1-IR)", extest_on, cur_op == 3'b000);
        step(1, 1);
        check(hiz_req == (cur_op == 3'b010), "R5 hiz before update (Update-IR)", hiz_req, cur_op == 3'b010);
        step(0, 1);
        cur_op = op;
        check(extest_on == (op == 3'b000), "R5 R9 extest after update", extest_on, op == 3'b000);
        check(hiz_req == (op == 3'b010), "R5 R10 hiz after update", hiz_req, op == 3'b010);
    endtask

    // From Run-Test/Idle: capture, shift n bits, update, back to idle.
    task automatic shift_dr(input int n, input logic [31:0] din, input logic [31:0] exp, input string req);
        for (int i = 0; i < n; i++) push(exp[i], req);
        step(1, 1); step(0, 1); step(0, 1);
        for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
        step(1, 1); step(0, 1);
    endtask

    // Scoreboard monitor: output-enable against the model, tdo against queue.
    initial begin
        exp_t e;
        forever begin
            @(negedge tck); #1;
            if (rst_n && !finished) begin
                check(tdo_oe == (mst == SHD || mst == SHI), "R2 tdo_oe vs state", tdo_oe, mst == SHD || mst == SHI);
                if (tdo_oe && sb_on) begin
                    if (sb_q.size() == 0) check(1'b0, "scoreboard underflow", tdo, 0);
                    else begin
                        e = sb_q.pop_front();
                        check(tdo == e.v, e.req, tdo, e.v);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge tck);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    localparam logic [0:43] WALK = 44'b10010001001011101011011000100101111010110111;

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge tck);
        #1;
        check(extest_on == 1'b0, "R1 extest after reset", extest_on, 0);
        check(hiz_req == 1'b0, "R1 hiz after reset", hiz_req, 0);
        check(pin_drv == '0, "R1 pin_drv after reset", pin_drv, 0);
        check(tdo_oe == 1'b0, "R1 tdo_oe after reset", tdo_oe, 0);
        @(negedge tck); #0.5; rst_n = 1'b1; mst = TLR;
        sb_on = 1'b1;

        // R6: identification shift-out right after reset
        step(0, 1);
        shift_dr(32, 32'h0, ID_VAL, "R6 idcode bit");

        // R7: pass-through for every opcode mapped to it
        load_ir(3'b111); d = 32'h0000_00B6; shift_dr(8, d, d << 1, "R7 bypass 111");
        load_ir(3'b011); d = 32'h0000_0035; shift_dr(6, d, d << 1, "R7 bypass 011");
        load_ir(3'b101); d = 32'h0000_00E9; shift_dr(8, d, d << 1, "R7 bypass 101");
        load_ir(3'b110); d = 32'h0000_001B; shift_dr(5, d, d << 1, "R7 bypass 110");

        // R8: sample then preload
        pin_cap = 16'hA5C3;
        load_ir(3'b100);
        shift_dr(BL, 32'h3C5A, {16'h0, 16'hA5C3}, "R8 sample bit");
        check(pin_drv == 16'h3C5A, "R8 preload to pin_drv", pin_drv, 16'h3C5A);
        check(extest_on == 1'b0, "R8 extest stays low", extest_on, 0);

        // R9: test drive
        pin_cap = 16'h0FF0;
        load_ir(3'b000);
        check(pin_drv == 16'h3C5A, "R9 preload kept on entry", pin_drv, 16'h3C5A);
        shift_dr(BL, 32'h1234, {16'h0, 16'h0FF0}, "R9 extest capture bit");
        check(pin_drv == 16'h1234, "R9 update drives pins", pin_drv, 16'h1234);

        // R10: high-impedance sample
        pin_cap = 16'h5555;
        load_ir(3'b010);
        shift_dr(BL, 32'hBEEF, {16'h0, 16'h5555}, "R10 samplez capture bit");
        check(pin_drv == 16'h1234, "R10 pin_drv unchanged", pin_drv, 16'h1234);
        check(hiz_req == 1'b1, "R10 hiz held", hiz_req, 1);

        // R3: five ones from Pause-IR reach reset, IDCODE restored
        load_ir(3'b111);
        sb_on = 1'b0;
        step(1, 1); step(1, 1); step(0, 1); step(0, 1); step(1, 1); step(0, 1); step(0, 1);
        for (int i = 0; i < 5; i++) step(1, 1);
        check(mst == TLR, "R3 model at reset", mst, TLR);
        step(0, 1);
        check(extest_on == 1'b0 && hiz_req == 1'b0, "R3 flags cleared", {extest_on, hiz_req}, 0);
        sb_on = 1'b1;
        shift_dr(32, 32'h0, ID_VAL, "R3 idcode after five ones");

        // R2: walk all 32 transitions, then prove arrival in reset
        sb_on = 1'b0;
        for (int i = 0; i < 5; i++) step(1, 1);
        for (int i = 0; i < 44; i++) step(WALK[i], 1);
        check(mst == TLR, "R2 walk ends at reset", mst, TLR);
        step(0, 1);
        sb_on = 1'b1;
        shift_dr(32, 32'h0, ID_VAL, "R2 idcode after walk");
        check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule